// File: doc/BRIEF.md
# MMU Alternate-Space Access Port

This block sits between a processor's alternate-address-space load/store path and the memory-management unit. Each access arrives as a one-cycle strobe carrying an address-space number, a virtual address, write data, an access size and a read/write flag. The space number selects the service. One space reaches a bank of sixteen 32-bit MMU control registers. Another space issues TLB probes on reads and TLB flush commands on stores. A range of sixteen spaces is forwarded straight to physical memory. Every other space reads as zero and drops its writes.

For both the register space and the probe/flush space, address bits [11:8] form a 4-bit field. In the register space the field is the register index. In the probe/flush space it is the operation level. Level 0 names a single page and levels 1 to 4 name progressively wider scopes.

Reading register 3 (fault status) or register 4 (fault address) clears the fault address register. Stores to register 0 (control) change only the enable and no-fault bits. Probe requests and memory requests are combinational, in the same cycle as the access. Read data and flush pulses are registered and appear one cycle later.

Top module: `mmu_asi_port`

## Requirements
- R1: Every read access (accValid high, accWrite low) raises rdValid for exactly the following cycle, and rdData carries the result in that cycle. Non-read cycles leave rdValid low in the next cycle.
- R2: A read in space 3 takes level = accAddr[11:8]. If the level is 4 or less, probeReq is high in the same cycle with probeLevel equal to the level and probeAddr equal to accAddr, and the next rdData is probeResult. If the level is above 4, no probe is issued and rdData is zero.
- R3: A read in space 4 returns register accAddr[11:8]. A write in space 4 to any index from 1 to 15 stores all 32 bits of accWdata.
- R4: A read of register 3 or register 4 returns the value held before the read, then clears register 4.
- R5: A write to register 0 replaces only bits [1:0] (bit 0 enable, bit 1 no-fault) with accWdata[1:0] and keeps bits [31:2].
- R6: A store in space 3 with level 0 produces flushPage high for one cycle in the next cycle, with flushPageAddr equal to accAddr with bits [11:0] cleared.
- R7: A store in space 3 with level 1, 2, 3 or 4 produces flushAll high for one cycle in the next cycle. A level above 4, and any other access, flushes nothing. The two flush outputs are never high together.
- R8: Spaces 0x20 to 0x2F drive memReq in the same cycle, with memWrite, memAddr = accAddr and memSize = accSize. Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit. The byte case keeps only bits [7:0]. The 16-bit case keeps bits [15:0] with their two bytes swapped. The 32-bit case reverses all four bytes. This mapping applies to memWdata on writes and to memRdata on reads, and the mapped read data is the next rdData.
- R9: A read in any space other than 3, 4 and 0x20 to 0x2F returns zero. A write there changes no register, produces no flush and no memory request.
- R10: After reset, all sixteen registers read as zero and rdValid, flushPage and flushAll are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Single-cycle access strobe |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAsi | input | 8 | Address-space number |
| accAddr | input | 32 | Access address |
| accWdata | input | 32 | Store data |
| accSize | input | 2 | 0 byte, 1 half, 2 word |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Read result |
| probeReq | output | 1 | TLB probe request (same cycle) |
| probeLevel | output | 4 | Probe level |
| probeAddr | output | 32 | Probe address |
| probeResult | input | 32 | Probe answer from the TLB |
| flushPage | output | 1 | Single-page flush pulse |
| flushPageAddr | output | 32 | Page-aligned flush address |
| flushAll | output | 1 | Full TLB flush pulse |
| memReq | output | 1 | Physical passthrough request |
| memWrite | output | 1 | Passthrough direction |
| memAddr | output | 32 | Passthrough address |
| memSize | output | 2 | Passthrough size code |
| memWdata | output | 32 | Byte-ordered store data |
| memRdata | input | 32 | Physical read data |

## Verification
The bench builds the block with its default parameters: a 4-bit level field, sixteen registers, 32-bit addresses and byte reordering enabled. Because the field is 4 bits wide, random addresses reach every register index and all sixteen levels. That covers the probe and flush levels above 4 as well as the boundary between levels 4 and 5. With reordering enabled, all three size codes give distinct, checkable data in both directions of the passthrough path.

// File: rtl/mmu_asi_pkg.sv
package mmu_asi_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_t;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic regRd;
    logic regWr;
    logic probeRd;
    logic zeroRd;
    logic passRd;
    logic passWr;
    logic flushPg;
    logic flushAll;
  } asiStrobes_t;

  // memory byte order: reorder to the access size
  function automatic logic [DATA_W-1:0] orderBytes(input logic [DATA_W-1:0] d,
                                                   input accSize_t sz);
    case (sz)
      SZ_BYTE: orderBytes = {24'd0, d[7:0]};
      SZ_HALF: orderBytes = {16'd0, d[7:0], d[15:8]};
      default: orderBytes = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  // native order: only trim to the access size
  function automatic logic [DATA_W-1:0] trimBytes(input logic [DATA_W-1:0] d,
                                                  input accSize_t sz);
    case (sz)
      SZ_BYTE: trimBytes = {24'd0, d[7:0]};
      SZ_HALF: trimBytes = {16'd0, d[15:0]};
      default: trimBytes = d;
    endcase
  endfunction

endpackage

// File: rtl/mmu_asi_ctrl.sv
module mmu_asi_ctrl
  import mmu_asi_pkg::*;
#(
  parameter int ASI_W     = 8,
  parameter int LVL_W     = 4,
  parameter int MAX_LEVEL = 4,
  parameter int PROBE_ASI = 3,
  parameter int REG_ASI   = 4,
  parameter int PASS_LO   = 32'h20,
  parameter int PASS_HI   = 32'h2F
) (
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [ASI_W-1:0] accAsi,
  input  logic [LVL_W-1:0] accLevel,
  output asiStrobes_t      strb
);

  logic isProbe, isReg, isPass, lvlOk, lvlZero, rdAcc, wrAcc;

  always_comb begin
    isProbe = (accAsi == ASI_W'(PROBE_ASI));
    isReg   = (accAsi == ASI_W'(REG_ASI));
    isPass  = (accAsi >= ASI_W'(PASS_LO)) && (accAsi <= ASI_W'(PASS_HI));
    lvlOk   = (accLevel <= LVL_W'(MAX_LEVEL));
    lvlZero = (accLevel == '0);
    rdAcc   = accValid && !accWrite;
    wrAcc   = accValid && accWrite;

    strb          = '0;
    strb.regRd    = rdAcc && isReg;
    strb.regWr    = wrAcc && isReg;
    strb.probeRd  = rdAcc && isProbe && lvlOk;
    strb.passRd   = rdAcc && isPass;
    strb.passWr   = wrAcc && isPass;
    strb.flushPg  = wrAcc && isProbe && lvlZero;
    strb.flushAll = wrAcc && isProbe && lvlOk && !lvlZero;
    // every other read answers zero (unknown space or probe level too high)
    strb.zeroRd   = rdAcc && !isReg && !isPass && !(isProbe && lvlOk);
  end

endmodule

// File: rtl/mmu_asi_datapath.sv
module mmu_asi_datapath
  import mmu_asi_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          LVL_W     = 4,
  parameter int          PAGE_BITS = 12,
  parameter logic [31:0] CTRL_MASK = 32'h0000_0003,
  parameter int          FSTAT_IDX = 3,
  parameter int          FADDR_IDX = 4,
  parameter bit          BSWAP     = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  asiStrobes_t                 strb,
  input  logic [LVL_W-1:0]            regIdx,
  input  logic [ADDR_W-PAGE_BITS-1:0] pageNum,
  input  logic [DATA_W-1:0]           accWdata,
  input  logic [1:0]                  accSize,
  input  logic [DATA_W-1:0]           probeResult,
  input  logic [DATA_W-1:0]           memRdata,
  output logic                        rdValid,
  output logic [DATA_W-1:0]           rdData,
  output logic                        flushPage,
  output logic [ADDR_W-1:0]           flushPageAddr,
  output logic                        flushAll,
  output logic                        probeReq,
  output logic                        memReq,
  output logic                        memWrite,
  output logic [DATA_W-1:0]           memWdata
);

  localparam int NUM_REGS = 1 << LVL_W;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] passRdData;
  logic              faultRd;

  // size handling variant picked by parameter
  generate
    if (BSWAP) begin : gSwap
      assign memWdata   = orderBytes(accWdata, accSize_t'(accSize));
      assign passRdData = orderBytes(memRdata, accSize_t'(accSize));
    end else begin : gNative
      assign memWdata   = trimBytes(accWdata, accSize_t'(accSize));
      assign passRdData = trimBytes(memRdata, accSize_t'(accSize));
    end
  endgenerate

  assign probeReq = strb.probeRd;
  assign memReq   = strb.passRd | strb.passWr;
  assign memWrite = strb.passWr;
  assign faultRd  = strb.regRd &&
                    (regIdx == LVL_W'(FSTAT_IDX) || regIdx == LVL_W'(FADDR_IDX));

  // register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (strb.regWr) begin
        if (regIdx == '0)
          regFile[0] <= (regFile[0] & ~CTRL_MASK) | (accWdata & CTRL_MASK);
        else
          regFile[regIdx] <= accWdata;
      end
      if (faultRd) regFile[FADDR_IDX] <= '0;
    end
  end

  // read return path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.regRd | strb.probeRd | strb.passRd | strb.zeroRd;
      if (strb.regRd)        rdData <= regFile[regIdx];
      else if (strb.probeRd) rdData <= probeResult;
      else if (strb.passRd)  rdData <= passRdData;
      else if (strb.zeroRd)  rdData <= '0;
    end
  end

  // flush pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPage     <= 1'b0;
      flushAll      <= 1'b0;
      flushPageAddr <= '0;
    end else begin
      flushPage <= strb.flushPg;
      flushAll  <= strb.flushAll;
      if (strb.flushPg) flushPageAddr <= {pageNum, PAGE_BITS'(0)};
    end
  end

endmodule

// File: rtl/mmu_asi_port.sv
module mmu_asi_port
  import mmu_asi_pkg::*;
#(
  parameter int ASI_W     = 8,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int LVL_LSB   = 8,
  parameter int PAGE_BITS = 12,
  parameter int MAX_LEVEL = 4,
  parameter bit BSWAP     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ASI_W-1:0]  accAsi,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [31:0]       accWdata,
  input  logic [1:0]        accSize,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              probeReq,
  output logic [LVL_W-1:0]  probeLevel,
  output logic [ADDR_W-1:0] probeAddr,
  input  logic [31:0]       probeResult,
  output logic              flushPage,
  output logic [ADDR_W-1:0] flushPageAddr,
  output logic              flushAll,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);

  asiStrobes_t      strb;
  logic [LVL_W-1:0] accLevel;

  assign accLevel   = accAddr[LVL_LSB +: LVL_W];
  assign probeLevel = accLevel;
  assign probeAddr  = accAddr;
  assign memAddr    = accAddr;
  assign memSize    = accSize;

  mmu_asi_ctrl #(
    .ASI_W    (ASI_W),
    .LVL_W    (LVL_W),
    .MAX_LEVEL(MAX_LEVEL)
  ) u_ctrl (
    .accValid(accValid),
    .accWrite(accWrite),
    .accAsi  (accAsi),
    .accLevel(accLevel),
    .strb    (strb)
  );

  mmu_asi_datapath #(
    .ADDR_W   (ADDR_W),
    .LVL_W    (LVL_W),
    .PAGE_BITS(PAGE_BITS),
    .BSWAP    (BSWAP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regIdx       (accLevel),
    .pageNum      (accAddr[ADDR_W-1:PAGE_BITS]),
    .accWdata     (accWdata),
    .accSize      (accSize),
    .probeResult  (probeResult),
    .memRdata     (memRdata),
    .rdValid      (rdValid),
    .rdData       (rdData),
    .flushPage    (flushPage),
    .flushPageAddr(flushPageAddr),
    .flushAll     (flushAll),
    .probeReq     (probeReq),
    .memReq       (memReq),
    .memWrite     (memWrite),
    .memWdata     (memWdata)
  );

endmodule

// File: rtl/mmu_asi_port_chk.sv
module mmu_asi_port_chk #(
  parameter int ASI_W     = 8,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int LVL_LSB   = 8,
  parameter int PAGE_BITS = 12,
  parameter int MAX_LEVEL = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ASI_W-1:0]  accAsi,
  input logic [ADDR_W-1:0] accAddr,
  input logic              rdValid,
  input logic [31:0]       rdData,
  input logic              probeReq,
  input logic [LVL_W-1:0]  probeLevel,
  input logic              flushPage,
  input logic [ADDR_W-1:0] flushPageAddr,
  input logic              flushAll,
  input logic              memReq
);

  logic knownAsi, isRead, pgStore;
  assign knownAsi = (accAsi == ASI_W'(3)) || (accAsi == ASI_W'(4)) ||
                    (accAsi >= ASI_W'(8'h20) && accAsi <= ASI_W'(8'h2F));
  assign isRead   = accValid && !accWrite;
  assign pgStore  = accValid && accWrite && (accAsi == ASI_W'(3)) &&
                    (accAddr[LVL_LSB +: LVL_W] == '0);

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid); // R1
  AST_PROBE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    probeReq |-> (isRead && accAsi == ASI_W'(3) && probeLevel <= LVL_W'(MAX_LEVEL))); // R2
  AST_PAGE_FLUSH_SRC: assert property (@(posedge clk) disable iff (!rstN)
    pgStore |=> flushPage); // R6
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    flushPage |-> (flushPageAddr[PAGE_BITS-1:0] == '0)); // R6
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flushPage && flushAll)); // R7
  AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (accValid && accAsi >= ASI_W'(8'h20) && accAsi <= ASI_W'(8'h2F))); // R8
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !knownAsi) |=> (rdData == '0)); // R9
  AST_UNKNOWN_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !knownAsi) |=> (!flushPage && !flushAll)); // R9

endmodule

bind mmu_asi_port mmu_asi_port_chk #(
  .ASI_W    (ASI_W),
  .ADDR_W   (ADDR_W),
  .LVL_W    (LVL_W),
  .LVL_LSB  (LVL_LSB),
  .PAGE_BITS(PAGE_BITS),
  .MAX_LEVEL(MAX_LEVEL)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accAsi       (accAsi),
  .accAddr      (accAddr),
  .rdValid      (rdValid),
  .rdData       (rdData),
  .probeReq     (probeReq),
  .probeLevel   (probeLevel),
  .flushPage    (flushPage),
  .flushPageAddr(flushPageAddr),
  .flushAll     (flushAll),
  .memReq       (memReq)
);

// File: tb/mmu_asi_port_bench.sv
`timescale 1ns/1ps
module mmu_asi_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [7:0]  accAsi = '0;
  logic [31:0] accAddr = '0;
  logic [31:0] accWdata = '0;
  logic [1:0]  accSize = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        probeReq;
  logic [3:0]  probeLevel;
  logic [31:0] probeAddr;
  logic [31:0] probeResult = '0;
  logic        flushPage;
  logic [31:0] flushPageAddr;
  logic        flushAll;
  logic        memReq;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  mmu_asi_port u_mmu_asi_port (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // byte arrangement expected by the size rules of R8
  function automatic logic [31:0] expOrder(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r = '0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int b = 0; b < n; b++) r[8*b +: 8] = d[8*(n-1-b) +: 8];
    return r;
  endfunction

  function automatic bit isPassAsi(input logic [7:0] a);
    return (a >= 8'h20) && (a <= 8'h2F);
  endfunction

  task automatic access(input bit wr, input logic [7:0] asi, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [1:0] sz);
    int lvl = int'(addr[11:8]);
    bit pass = isPassAsi(asi);
    bit expProbe = !wr && asi == 8'd3 && lvl <= 4;
    logic [31:0] expRd = '0;
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAsi = asi; accAddr = addr;
    accWdata = wd; accSize = sz;
    probeResult = addr ^ 32'h5A5A_0F0F;
    memRdata = ~addr + 32'h0001_2345;
    #1;
    check("R2 probeReq", 32'(probeReq), 32'(expProbe));
    if (expProbe) begin
      check("R2 probeLevel", 32'(probeLevel), 32'(lvl));
      check("R2 probeAddr", probeAddr, addr);
    end
    check(pass ? "R8 memReq" : "R9 memReq", 32'(memReq), 32'(pass));
    if (pass) begin
      check("R8 memWrite", 32'(memWrite), 32'(wr));
      check("R8 memAddr", memAddr, addr);
      check("R8 memSize", 32'(memSize), 32'(sz));
      if (wr) check("R8 memWdata", memWdata, expOrder(wd, sz));
    end
    // reference model update
    if (!wr) begin
      if (asi == 8'd4) begin
        expRd = model[lvl];
        if (lvl == 3 || lvl == 4) model[4] = '0;
      end else if (asi == 8'd3) begin
        expRd = (lvl <= 4) ? (addr ^ 32'h5A5A_0F0F) : 32'h0;
      end else if (pass) begin
        expRd = expOrder(~addr + 32'h0001_2345, sz);
      end
    end else if (asi == 8'd4) begin
      if (lvl == 0) model[0] = {model[0][31:2], wd[1:0]};
      else model[lvl] = wd;
    end
    @(negedge clk);
    accValid = 1'b0;
    check("R1 rdValid", 32'(rdValid), 32'(!wr));
    if (!wr) begin
      if (asi == 8'd4) check((lvl == 3 || lvl == 4) ? "R4 fault read" :
                             (lvl == 0) ? "R5 ctrl read" : "R3 reg read", rdData, expRd);
      else if (asi == 8'd3) check("R2 probe data", rdData, expRd);
      else if (pass) check("R8 pass read", rdData, expRd);
      else check("R9 unknown read", rdData, expRd);
    end
    check("R6 flushPage", 32'(flushPage), 32'(wr && asi == 8'd3 && lvl == 0));
    if (wr && asi == 8'd3 && lvl == 0)
      check("R6 flushPageAddr", flushPageAddr, {addr[31:12], 12'h000});
    check("R7 flushAll", 32'(flushAll), 32'(wr && asi == 8'd3 && lvl >= 1 && lvl <= 4));
    @(negedge clk);
    check("R7 single pulse", 32'({flushPage, flushAll}), 32'd0);
  endtask

  function automatic logic [31:0] regAddr(input int idx);
    return {$urandom} & 32'hFFFF_F0FF | (32'(idx) << 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rdValid", 32'(rdValid), 32'd0);
    check("R10 flush", 32'({flushPage, flushAll}), 32'd0);
    for (int i = 0; i < 16; i++) access(1'b0, 8'd4, regAddr(i), '0, 2'd2);

    // R5 control register masking
    access(1'b1, 8'd4, 32'h0000_0000, 32'hFFFF_FFFF, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0000, '0, 2'd2);
    access(1'b1, 8'd4, 32'h0000_0000, 32'hFFFF_FFFE, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0000, '0, 2'd2);

    // R3/R4 fault registers
    access(1'b1, 8'd4, 32'h0000_0300, 32'hA1A2_A3A4, 2'd2);
    access(1'b1, 8'd4, 32'h0000_0400, 32'hB1B2_B3B4, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0400, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0400, '0, 2'd2);
    access(1'b1, 8'd4, 32'h0000_0400, 32'hC0DE_0004, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0300, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0300, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0400, '0, 2'd2);
    access(1'b1, 8'd4, 32'h0000_0F00, 32'h1234_5678, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0F00, '0, 2'd2);

    // R2 probe level boundaries
    access(1'b0, 8'd3, 32'h1234_5000, '0, 2'd2);
    access(1'b0, 8'd3, 32'h1234_5400, '0, 2'd2);
    access(1'b0, 8'd3, 32'h1234_5500, '0, 2'd2);
    access(1'b0, 8'd3, 32'h1234_5F00, '0, 2'd2);

    // R6/R7 flush level boundaries
    access(1'b1, 8'd3, 32'hDEAD_BEEF & 32'hFFFF_F0FF, '0, 2'd2);
    access(1'b1, 8'd3, 32'h0000_0100, '0, 2'd2);
    access(1'b1, 8'd3, 32'h0000_0400, '0, 2'd2);
    access(1'b1, 8'd3, 32'h0000_0500, '0, 2'd2);

    // R8 passthrough sizes, both range ends
    for (int s = 0; s < 3; s++) begin
      access(1'b1, 8'h20, 32'h8000_0010, 32'h1122_3344, 2'(s));
      access(1'b0, 8'h2F, 32'h8000_0020, '0, 2'(s));
    end

    // R9 unknown spaces: writes change nothing, reads give zero
    access(1'b1, 8'h1F, 32'h0000_0300, 32'hFFFF_FFFF, 2'd2);
    access(1'b1, 8'h30, 32'h0000_0000, 32'hFFFF_FFFF, 2'd2);
    access(1'b1, 8'h05, 32'h0000_0F00, 32'hFFFF_FFFF, 2'd2);
    access(1'b0, 8'h30, 32'h0000_0000, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0300, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0000, '0, 2'd2);
    access(1'b0, 8'd4, 32'h0000_0F00, '0, 2'd2);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      int pick = $urandom_range(0, 9);
      if (pick < 3)       a = 8'd4;
      else if (pick < 6)  a = 8'd3;
      else if (pick < 8)  a = 8'h20 + 8'($urandom_range(0, 15));
      else                a = 8'($urandom);
      access(1'($urandom), a, $urandom, $urandom, 2'($urandom_range(0, 2)));
    end

    // final sweep of the register bank
    for (int i = 0; i < 16; i++) access(1'b0, 8'd4, regAddr(i), '0, 2'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule